// File: doc/BRIEF.md
# Phased External Bus Access Sequencer

The sequencer runs one external memory access at a time for a host. The host raises a request and holds it, along with the address, the write data, the direction and three phase lengths. The block then steps through three phases on the external bus, each a whole number of timing-clock cycles long. In the first phase the chip-select and direction are set up. In the second phase the read or write strobe is low. In the third phase the strobe is high again and the chip-select is still held. A one-cycle acknowledge ends the access and, for reads, carries the captured data.

The block also drives an external bus clock that toggles on every timing-clock cycle. Each access starts on a rising edge of this clock. If the clock is high when a request arrives, the block inserts one idle alignment cycle first. Because of this, the strobe edges land on a rising or a falling bus-clock edge according to the parity of the cycle counts that come before them. Between accesses the address bus holds the last address, except that bit 0 is forced high.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset the bus clock is low, and it inverts on every timing-clock cycle.
- R2: Chip-select falls in the same cycle in which the bus clock turns high. If the bus clock is high in the cycle a request is first seen, chip-select falls two cycles later; otherwise it falls one cycle later.
- R3: Chip-select stays low for L+A+T cycles, where L, A and T are the lead, active and trail lengths (3 bits each, 1 to 7, with a value of 0 treated as 1). The strobe is low for exactly A cycles, and it falls L cycles after chip-select falls.
- R4: The strobe falls while the bus clock is high when L is even, and while it is low when L is odd. The strobe rises while the bus clock is high when L+A is even, and while it is low when L+A is odd.
- R5: A read (direction input 0) pulses only the read strobe and keeps read/not-write high. A write (direction input 1) pulses only the write strobe and holds read/not-write low for the whole time chip-select is low.
- R6: While chip-select is low, the address bus carries the full request address. While it is high, the address bus carries the last address with bit 0 forced to 1.
- R7: For a write, the output enable is high, with the write data on the data-out bus, from the first active cycle to the last trail cycle, A+T cycles in all. At every other time the output enable is low.
- R8: Read data is sampled at the clock edge that ends the active phase. Changes to the data-in bus after that edge do not change the returned data.
- R9: The acknowledge is high for exactly one cycle, the last trail cycle, and read data is valid on that cycle. A request held in the following cycle starts a new access.
- R10: During and right after reset, chip-select, both strobes and read/not-write are high, the output enable and acknowledge are low, and the address bus reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until acknowledge |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_lead | input | PW | Lead length in cycles |
| req_active | input | PW | Active length in cycles |
| req_trail | input | PW | Trail length in cycles |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Captured read data |
| bus_clk | output | 1 | Half-rate external bus clock |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_rnw | output | 1 | Read/not-write |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | AW | External address bus |
| bus_dout | output | DW | Data driven to the external bus |
| bus_oe | output | 1 | Output enable for the data bus |
| bus_din | input | DW | Data returned from the external bus |

## Verification
The assertions assume the host keeps the request and all its fields steady from the cycle it rises until the acknowledge cycle, and that it never raises a request in the acknowledge cycle itself. The stimulus respects this. Every request is driven away from the clock edge and held unchanged until the acknowledge is seen. The request then drops in that same cycle and rises again no sooner than the next one, and each new request is raised while the bus clock is randomly high or low, so both alignment paths are exercised.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [PW-1:0] req_lead,
  input  logic [PW-1:0] req_active,
  input  logic [PW-1:0] req_trail,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          bus_clk,
  output logic          bus_cs_n,
  output logic          bus_rnw,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din
);

  typedef enum logic [2:0] {S_IDLE, S_ALIGN, S_LEAD, S_ACT, S_TRAIL} st_t;

  st_t           st;
  logic [PW-1:0] cnt, act_q, trl_q;
  logic          wr_q, clk_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, rd_q;

  function automatic logic [PW-1:0] to_cnt(input logic [PW-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  wire start  = (st == S_IDLE && req && !clk_q) || st == S_ALIGN;
  wire last   = (cnt == '0);
  wire in_acc = (st == S_LEAD) || (st == S_ACT) || (st == S_TRAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      act_q  <= '0;
      trl_q  <= '0;
      wr_q   <= 1'b0;
      clk_q  <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      clk_q <= ~clk_q;
      case (st)
        S_IDLE:  if (req) st <= clk_q ? S_ALIGN : S_LEAD;
        S_ALIGN: st <= S_LEAD;
        S_LEAD:
          if (last) begin
            st  <= S_ACT;
            cnt <= act_q;
          end else cnt <= cnt - 1'b1;
        S_ACT:
          if (last) begin
            st  <= S_TRAIL;
            cnt <= trl_q;
            if (!wr_q) rd_q <= bus_din;
          end else cnt <= cnt - 1'b1;
        S_TRAIL:
          if (last) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
      if (start) begin
        addr_q <= req_addr;
        wd_q   <= req_wdata;
        wr_q   <= req_wr;
        cnt    <= to_cnt(req_lead);
        act_q  <= to_cnt(req_active);
        trl_q  <= to_cnt(req_trail);
      end
    end
  end

  assign bus_clk  = clk_q;
  assign bus_cs_n = ~in_acc;
  assign bus_rnw  = ~(in_acc && wr_q);
  assign bus_rd_n = ~(st == S_ACT && !wr_q);
  assign bus_wr_n = ~(st == S_ACT && wr_q);
  assign bus_addr = in_acc ? addr_q : {addr_q[AW-1:1], 1'b1};
  assign bus_dout = wd_q;
  assign bus_oe   = wr_q && (st == S_ACT || st == S_TRAIL);
  assign ack      = (st == S_TRAIL) && last;
  assign rdata    = rd_q;

endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          req_wr,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic [PW-1:0] req_lead,
  input logic [PW-1:0] req_active,
  input logic [PW-1:0] req_trail,
  input logic          ack,
  input logic [DW-1:0] rdata,
  input logic          bus_clk,
  input logic          bus_cs_n,
  input logic          bus_rnw,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_dout,
  input logic          bus_oe,
  input logic [DW-1:0] bus_din
);

  a_r1_clk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bus_clk != $past(bus_clk));

  a_r2_cs_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> bus_clk);

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_n || bus_wr_n);

  a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

  a_r6_idle_addr0: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |-> bus_addr[0]);

  a_r7_oe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!bus_cs_n && !bus_rnw && bus_rd_n));

  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!ack && bus_cs_n));

  a_r9_ack_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (!bus_cs_n && bus_rd_n && bus_wr_n));

endmodule

bind ext_bus_seq ext_bus_seq_chk #(.AW(AW), .DW(DW), .PW(PW)) u_chk (.*);

// File: tb/ext_bus_seq_bench.sv
module ext_bus_seq_bench;
  localparam int AW = 16, DW = 16, PW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_din = '0;
  logic [PW-1:0] req_lead = '0, req_active = '0, req_trail = '0;
  logic ack, bus_clk, bus_cs_n, bus_rnw, bus_rd_n, bus_wr_n, bus_oe;
  logic [DW-1:0] rdata, bus_dout;
  logic [AW-1:0] bus_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_bus_seq #(.AW(AW), .DW(DW), .PW(PW)) u_ext_bus_seq (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input logic [PW-1:0] n);
    return (n == 0) ? 1 : int'(n);
  endfunction

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] din, input logic [PW-1:0] l,
                        input logic [PW-1:0] ac, input logic [PW-1:0] t);
    int L, A, T, wait_n, exp_wait, cs_n_cyc, st_cyc, st_off, oe_cyc, guard;
    bit clk_at_req, st_fall_clk, st_rise_clk, seen_st, seen_rise, addr_ok, rnw_ok, wrong_strobe, dout_ok;
    L = eff(l); A = eff(ac); T = eff(t);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd;
    req_lead = l; req_active = ac; req_trail = t; bus_din = din;
    clk_at_req = bus_clk;
    exp_wait = clk_at_req ? 2 : 1;
    wait_n = 0; cs_n_cyc = 0; st_cyc = 0; st_off = 0; oe_cyc = 0; guard = 0;
    seen_st = 0; seen_rise = 0; addr_ok = 1; rnw_ok = 1; wrong_strobe = 0; dout_ok = 1;
    st_fall_clk = 0; st_rise_clk = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (guard > 100) begin
        chk(0, "R9 watchdog", guard, 0);
        req = 1'b0;
        return;
      end
      if (bus_cs_n) begin
        wait_n++;
        continue;
      end
      if (cs_n_cyc == 0) begin
        chk(wait_n + 1 == exp_wait, "R2 start delay", wait_n + 1, exp_wait);
        chk(bus_clk == 1'b1, "R2 cs falls on rise", bus_clk, 1);
      end
      cs_n_cyc++;
      if (bus_addr != a) addr_ok = 0;
      if (bus_rnw != !wr) rnw_ok = 0;
      if (bus_oe) begin
        oe_cyc++;
        if (bus_dout != wd) dout_ok = 0;
      end
      if ((wr && !bus_rd_n) || (!wr && !bus_wr_n)) wrong_strobe = 1;
      if (!(wr ? bus_wr_n : bus_rd_n)) begin
        if (!seen_st) begin
          seen_st = 1; st_off = cs_n_cyc - 1; st_fall_clk = bus_clk;
        end
        st_cyc++;
      end else if (seen_st && !seen_rise) begin
        seen_rise = 1; st_rise_clk = bus_clk;
        bus_din = ~din;
      end
      if (ack) break;
    end
    chk(cs_n_cyc == L + A + T, "R3 cs length", cs_n_cyc, L + A + T);
    chk(st_cyc == A, "R3 strobe length", st_cyc, A);
    chk(st_off == L, "R3 strobe offset", st_off, L);
    chk(st_fall_clk == ((L % 2) == 0), "R4 fall parity", st_fall_clk, (L % 2) == 0);
    chk(st_rise_clk == (((L + A) % 2) == 0), "R4 rise parity", st_rise_clk, ((L + A) % 2) == 0);
    chk(!wrong_strobe && rnw_ok, "R5 strobe and rnw", wrong_strobe, 0);
    chk(addr_ok, "R6 access addr", addr_ok, 1);
    chk(oe_cyc == (wr ? A + T : 0) && dout_ok, "R7 oe window", oe_cyc, wr ? A + T : 0);
    if (!wr) chk(rdata == din, "R8 read capture", rdata, din);
    req = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0 && bus_cs_n, "R9 ack single", ack, 0);
    chk(bus_addr == {a[AW-1:1], 1'b1}, "R6 idle addr", bus_addr, {a[AW-1:1], 1'b1});
    chk(!bus_oe, "R7 oe off", bus_oe, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      chk(0, "R9 global watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #2;
    chk(bus_cs_n && bus_rd_n && bus_wr_n && bus_rnw && !bus_oe && !ack && bus_addr == 1,
        "R10 reset outputs", {bus_cs_n, bus_rd_n, bus_wr_n, bus_rnw, bus_oe, ack}, 6'b111100);
    chk(bus_clk == 1'b0, "R1 reset clk low", bus_clk, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_clk == 1'b1, "R1 first toggle", bus_clk, 1);
    @(negedge clk);
    chk(bus_clk == 1'b0, "R1 second toggle", bus_clk, 0);
    chk(bus_cs_n && bus_addr == 1, "R10 idle after reset", bus_addr, 1);

    access(0, 16'h1234, 16'h0, 16'hBEEF, 3'd1, 3'd1, 3'd1);
    access(1, 16'hA5A4, 16'h5A5A, 16'h0, 3'd7, 3'd7, 3'd7);
    access(0, 16'h0F0E, 16'h0, 16'hC0DE, 3'd0, 3'd0, 3'd0);
    access(1, 16'h8001, 16'h1111, 16'h0, 3'd2, 3'd3, 3'd1);
    access(0, 16'h7776, 16'h0, 16'h4321, 3'd3, 3'd2, 3'd4);
    @(negedge clk);
    access(1, 16'h2222, 16'hFFFF, 16'h0, 3'd4, 3'd1, 3'd2);

    for (int i = 0; i < 60; i++) begin
      int gap;
      gap = int'($urandom_range(0, 2));
      repeat (gap) @(negedge clk);
      access($urandom_range(0, 1), AW'($urandom), DW'($urandom), DW'($urandom),
             PW'($urandom_range(0, 7)), PW'($urandom_range(0, 7)), PW'($urandom_range(0, 7)));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule